// File: doc/BRIEF.md
# Wavefront Issue Scheduler

This block decides, once per clock, which resident wavefront contexts issue their next instruction. Up to `N_SLOTS` wavefront slots each present a valid flag, a ready flag (the head instruction has its operands and may go), a 4-bit instruction kind, a small immediate and the count of that wavefront's vector-memory operations still in flight. Five functional-unit categories are arbitrated independently and each gets its own grant output. Wavefronts that are not ready, or that are asleep, are passed over.

Instructions that need no functional unit are resolved inside the scheduler: the no-op, the sleep, the wait on the outstanding memory count and the group barrier. Each of them is consumed through the per-slot pop output without using an issue port. The fetch side uses the pop output to advance each slot to its next instruction.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset every category's round-robin pointer is at slot 0 and no slot is asleep, so with all slots requesting one category, slot 0 wins first.
- R2: A category grants at most one slot per cycle, and only a slot that is valid, ready, not asleep and whose head kind is that category.
- R3: Each category picks the first requesting slot at or above its pointer, wrapping from slot N_SLOTS-1 to 0. After a grant, the pointer moves to the winner plus one (wrapping to 0). Without a grant, it stays unchanged.
- R4: A slot with ready low, or with valid low, gets no grant and no pop whatever its kind, and does not block other slots.
- R5: The kind codes 0 vector ALU, 1 scalar ALU/branch, 2 vector memory, 3 local data share and 4 export map to grant lanes 0 to 4. All five lanes may grant in the same cycle, each to a different slot.
- R6: A slot wins at most one category per cycle. `slot_pop` is high for exactly the slots that were granted or whose special instruction was resolved in that cycle.
- R7: Kind 5 (no-op) and the spare codes 9 to 15 are popped in the same cycle on a runnable slot, without any grant.
- R8: Kind 6 (sleep) with immediate k is popped on a runnable slot, and that slot is then not runnable for the next k cycles.
- R9: Kind 7 (wait on count) with immediate t is held, not popped, while the slot's outstanding vector-memory count exceeds t. It is popped in the first cycle in which the count is t or less.
- R10: Kind 8 (barrier) is popped on all valid slots together, in the first cycle in which every valid slot is runnable with a barrier at its head. Until then, no barrier is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | N_SLOTS | Slot holds a resident wavefront |
| slot_ready | input | N_SLOTS | Head instruction of the slot may issue |
| slot_kind | input | N_SLOTS*4 | Head instruction kind per slot |
| slot_imm | input | N_SLOTS*IMM_W | Sleep length or count threshold per slot |
| slot_vmcnt | input | N_SLOTS*CNT_W | Outstanding vector-memory operations per slot |
| gnt_vld | output | 5 | A grant exists in each category lane |
| gnt_slot | output | 5*SLOT_W | Winning slot index per category lane |
| slot_pop | output | N_SLOTS | Head instruction of the slot is consumed this cycle |

## Verification
Saturated single-category traffic walks each pointer around the full ring and past the wrap point. Sparse ready masks and ready-but-invalid slots separate correct skipping from a scan that stops early or from a plain priority encoder. Directed cycles with all five kinds on separate slots, and mixed special kinds, show that the lanes are independent and that special instructions never take a grant. Sleep lengths, count thresholds just above and at the limit, and barriers with one straggler pin down the exact release cycle. Long seeded random traffic then compares every grant and pop against a cycle model.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  localparam int NUM_CAT = 5;
  localparam int KIND_W  = 4;
  localparam int MAX_SLOTS = 32;

  localparam logic [KIND_W-1:0] K_VALU  = 4'd0;
  localparam logic [KIND_W-1:0] K_SALU  = 4'd1;
  localparam logic [KIND_W-1:0] K_VMEM  = 4'd2;
  localparam logic [KIND_W-1:0] K_LDS   = 4'd3;
  localparam logic [KIND_W-1:0] K_EXP   = 4'd4;
  localparam logic [KIND_W-1:0] K_NOP   = 4'd5;
  localparam logic [KIND_W-1:0] K_SLEEP = 4'd6;
  localparam logic [KIND_W-1:0] K_WAIT  = 4'd7;
  localparam logic [KIND_W-1:0] K_BAR   = 4'd8;

  // kind needs one of the issue ports
  function automatic logic uses_port(input logic [KIND_W-1:0] k);
    return k < 4'(NUM_CAT);
  endfunction

  // circular first-set search starting at ptr
  function automatic int unsigned rr_first(input logic [MAX_SLOTS-1:0] req,
                                           input int unsigned ptr);
    logic [MAX_SLOTS-1:0] upper;
    int unsigned lo_pick;
    int unsigned hi_pick;
    upper   = req & ~((MAX_SLOTS'(1) << ptr) - MAX_SLOTS'(1));
    lo_pick = 0;
    hi_pick = 0;
    for (int k = MAX_SLOTS - 1; k >= 0; k--) begin
      if (req[k])   lo_pick = unsigned'(k);
      if (upper[k]) hi_pick = unsigned'(k);
    end
    return (|upper) ? hi_pick : lo_pick;
  endfunction

  function automatic int unsigned ptr_after(input int unsigned idx,
                                            input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  function automatic logic count_met(input int unsigned cnt,
                                     input int unsigned thr);
    return cnt <= thr;
  endfunction

endpackage

// File: rtl/wsched_slot_ctl.sv
module wsched_slot_ctl
  import wsched_pkg::*;
#(
  parameter int IMM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              ready,
  input  logic [KIND_W-1:0] kind,
  input  logic [IMM_W-1:0]  imm,
  input  logic              pop,
  output logic              runnable
);

  logic [IMM_W-1:0] nap_left;
  logic             nap_load;

  assign nap_load = pop && (kind == K_SLEEP);
  assign runnable = valid && ready && (nap_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nap_left <= '0;
    end else if (nap_load) begin
      nap_left <= imm;
    end else if (nap_left != '0) begin
      nap_left <= nap_left - IMM_W'(1);
    end
  end

  // R8: a popped sleep with a nonzero length blocks the slot next cycle
  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && kind == K_SLEEP && imm != '0) |=> !runnable);

endmodule

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb
  import wsched_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int SLOT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req,
  output logic               gnt_vld,
  output logic [SLOT_W-1:0]  gnt_idx
);

  logic [SLOT_W-1:0]    ptr;
  logic [MAX_SLOTS-1:0] req_ext;
  int unsigned          pick;
  logic                 started;

  always_comb begin
    req_ext = '0;
    req_ext[N_SLOTS-1:0] = req;
    pick    = rr_first(req_ext, {{(32-SLOT_W){1'b0}}, ptr});
    gnt_vld = |req;
    gnt_idx = SLOT_W'(pick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (gnt_vld) ptr <= SLOT_W'(ptr_after(pick, N_SLOTS));
    end
  end

  // R2: a grant only ever lands on a requesting slot
  a_r2_gnt_requested: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((req >> gnt_idx) & N_SLOTS'(1)) != '0);

  // R3: pointer steps past the previous winner
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(gnt_vld)) |->
      ptr == (($past(gnt_idx) == SLOT_W'(N_SLOTS - 1)) ? '0 : $past(gnt_idx) + SLOT_W'(1)));

  // R3: pointer holds when nothing was granted
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(gnt_vld)) |-> $stable(ptr));

endmodule

// File: rtl/wsched_special.sv
module wsched_special
  import wsched_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int IMM_W   = 6,
  parameter int CNT_W   = 6
) (
  input  logic [N_SLOTS-1:0]        valid,
  input  logic [N_SLOTS-1:0]        runnable,
  input  logic [N_SLOTS*KIND_W-1:0] kind,
  input  logic [N_SLOTS*IMM_W-1:0]  imm,
  input  logic [N_SLOTS*CNT_W-1:0]  vmcnt,
  output logic [N_SLOTS-1:0]        spec_pop,
  output logic                      bar_release
);

  logic [N_SLOTS-1:0] at_barrier;

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      at_barrier[i] = runnable[i] && (kind[i*KIND_W +: KIND_W] == K_BAR);
    end
    bar_release = (|at_barrier) && ((at_barrier | ~valid) == '1);
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic [KIND_W-1:0] k_i;
    logic [IMM_W-1:0]  imm_i;
    logic [CNT_W-1:0]  cnt_i;
    assign k_i   = kind[i*KIND_W +: KIND_W];
    assign imm_i = imm[i*IMM_W +: IMM_W];
    assign cnt_i = vmcnt[i*CNT_W +: CNT_W];

    always_comb begin
      if (uses_port(k_i)) begin
        spec_pop[i] = 1'b0;
      end else if (k_i == K_BAR) begin
        spec_pop[i] = bar_release && at_barrier[i];
      end else if (k_i == K_WAIT) begin
        spec_pop[i] = runnable[i] &&
                      count_met({{(32-CNT_W){1'b0}}, cnt_i}, {{(32-IMM_W){1'b0}}, imm_i});
      end else begin
        spec_pop[i] = runnable[i];
      end
    end
  end

endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wsched_pkg::*;
#(
  parameter int N_SLOTS = 10,
  parameter int IMM_W   = 6,
  parameter int CNT_W   = 6,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS-1:0]        slot_ready,
  input  logic [N_SLOTS*KIND_W-1:0] slot_kind,
  input  logic [N_SLOTS*IMM_W-1:0]  slot_imm,
  input  logic [N_SLOTS*CNT_W-1:0]  slot_vmcnt,
  output logic [NUM_CAT-1:0]        gnt_vld,
  output logic [NUM_CAT*SLOT_W-1:0] gnt_slot,
  output logic [N_SLOTS-1:0]        slot_pop
);

  logic [N_SLOTS-1:0] runnable;
  logic [N_SLOTS-1:0] spec_pop;
  logic               bar_release;
  logic [N_SLOTS-1:0] cat_req [NUM_CAT];
  logic [NUM_CAT-1:0] slot_hit [N_SLOTS];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_ctl
    wsched_slot_ctl #(.IMM_W(IMM_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (slot_valid[i]),
      .ready    (slot_ready[i]),
      .kind     (slot_kind[i*KIND_W +: KIND_W]),
      .imm      (slot_imm[i*IMM_W +: IMM_W]),
      .pop      (slot_pop[i]),
      .runnable (runnable[i])
    );
  end

  always_comb begin
    for (int c = 0; c < NUM_CAT; c++) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        cat_req[c][i] = runnable[i] && (slot_kind[i*KIND_W +: KIND_W] == KIND_W'(c));
      end
    end
  end

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    wsched_rr_arb #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (cat_req[c]),
      .gnt_vld (gnt_vld[c]),
      .gnt_idx (gnt_slot[c*SLOT_W +: SLOT_W])
    );
  end

  wsched_special #(.N_SLOTS(N_SLOTS), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_spec (
    .valid       (slot_valid),
    .runnable    (runnable),
    .kind        (slot_kind),
    .imm         (slot_imm),
    .vmcnt       (slot_vmcnt),
    .spec_pop    (spec_pop),
    .bar_release (bar_release)
  );

  always_comb begin
    for (int i = 0; i < N_SLOTS; i++) begin
      for (int c = 0; c < NUM_CAT; c++) begin
        slot_hit[i][c] = gnt_vld[c] && (gnt_slot[c*SLOT_W +: SLOT_W] == SLOT_W'(i));
      end
      slot_pop[i] = spec_pop[i] || (|slot_hit[i]);
    end
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    logic [KIND_W-1:0] k_i;
    assign k_i = slot_kind[i*KIND_W +: KIND_W];

    // R6: the independent lanes never share a winner
    a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_hit[i]));

    // R9: a wait is consumed only once the count is at or under the limit
    a_r9_wait_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_pop[i] && k_i == K_WAIT) |->
        slot_vmcnt[i*CNT_W +: CNT_W] <= slot_imm[i*IMM_W +: IMM_W]);

    // R10: a barrier leaves only together with every valid slot
    a_r10_group_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_pop[i] && k_i == K_BAR) |-> ((slot_valid & ~slot_pop) == '0));

    // R4: a slot that is not ready is never consumed
    a_r4_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_ready[i] |-> !slot_pop[i]);
  end

endmodule

// File: tb/tb_wave_issue_sched.sv
`timescale 1ns/1ps
module tb_wave_issue_sched;
  localparam int N  = 10;
  localparam int NC = 5;
  localparam int KW = 4;
  localparam int IW = 6;
  localparam int CW = 6;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    slot_valid = '0;
  logic [N-1:0]    slot_ready = '0;
  logic [N*KW-1:0] slot_kind  = '0;
  logic [N*IW-1:0] slot_imm   = '0;
  logic [N*CW-1:0] slot_vmcnt = '0;
  logic [NC-1:0]    gnt_vld;
  logic [NC*SW-1:0] gnt_slot;
  logic [N-1:0]     slot_pop;

  wave_issue_sched #(.N_SLOTS(N), .IMM_W(IW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_kind(slot_kind), .slot_imm(slot_imm), .slot_vmcnt(slot_vmcnt),
    .gnt_vld(gnt_vld), .gnt_slot(gnt_slot), .slot_pop(slot_pop)
  );

  int s_valid[N], s_ready[N], s_kind[N], s_imm[N], s_vm[N];
  int ptr_m[NC];
  int nap_m[N];
  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    for (int i = 0; i < N; i++) begin
      s_valid[i] = 0; s_ready[i] = 0; s_kind[i] = 0; s_imm[i] = 0; s_vm[i] = 0;
    end
  endtask

  task automatic cyc(input string rq, input int exp_pop, input int exp_v0);
    int run[N];
    int e_vld[NC];
    int e_idx[NC];
    int e_pop;
    int any_b, all_b, idx;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      slot_valid[i] = s_valid[i][0];
      slot_ready[i] = s_ready[i][0];
      slot_kind[i*KW +: KW] = KW'(s_kind[i]);
      slot_imm[i*IW +: IW]  = IW'(s_imm[i]);
      slot_vmcnt[i*CW +: CW] = CW'(s_vm[i]);
    end
    #1;
    for (int i = 0; i < N; i++) run[i] = (s_valid[i] != 0 && s_ready[i] != 0 && nap_m[i] == 0) ? 1 : 0;
    e_pop = 0;
    for (int c = 0; c < NC; c++) begin
      e_vld[c] = 0; e_idx[c] = 0;
      for (int k = 0; k < N; k++) begin
        idx = (ptr_m[c] + k) % N;
        if (e_vld[c] == 0 && run[idx] == 1 && s_kind[idx] == c) begin
          e_vld[c] = 1; e_idx[c] = idx;
        end
      end
      if (e_vld[c] == 1) e_pop |= (1 << e_idx[c]);
    end
    any_b = 0; all_b = 1;
    for (int i = 0; i < N; i++) begin
      if (s_valid[i] != 0) begin
        if (run[i] == 1 && s_kind[i] == 8) any_b = 1;
        else all_b = 0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (s_kind[i] == 8) begin
        if (any_b == 1 && all_b == 1 && run[i] == 1) e_pop |= (1 << i);
      end else if (s_kind[i] == 7) begin
        if (run[i] == 1 && s_vm[i] <= s_imm[i]) e_pop |= (1 << i);
      end else if (s_kind[i] >= 5) begin
        if (run[i] == 1) e_pop |= (1 << i);
      end
    end
    for (int c = 0; c < NC; c++) begin
      check({rq, " lane valid"}, int'(gnt_vld[c]), e_vld[c]);
      if (e_vld[c] == 1) check({rq, " lane slot"}, int'(gnt_slot[c*SW +: SW]), e_idx[c]);
    end
    check({rq, " pop"}, int'(slot_pop), e_pop);
    if (exp_pop >= 0) check({rq, " directed pop"}, int'(slot_pop), exp_pop);
    if (exp_v0 == -2) check({rq, " no valu grant"}, int'(gnt_vld[0]), 0);
    else if (exp_v0 >= 0) begin
      check({rq, " valu grant"}, int'(gnt_vld[0]), 1);
      check({rq, " valu slot"}, int'(gnt_slot[SW-1:0]), exp_v0);
    end
    for (int c = 0; c < NC; c++) if (e_vld[c] == 1) ptr_m[c] = (e_idx[c] + 1) % N;
    for (int i = 0; i < N; i++) begin
      if (((e_pop >> i) & 1) == 1 && s_kind[i] == 6) nap_m[i] = s_imm[i];
      else if (nap_m[i] > 0) nap_m[i]--;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++) ptr_m[c] = 0;
    for (int i = 0; i < N; i++) nap_m[i] = 0;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R3: all slots want the vector ALU; ring walk with wrap
    for (int i = 0; i < N; i++) begin s_valid[i] = 1; s_ready[i] = 1; s_kind[i] = 0; end
    cyc("R1 reset pointer", 1, 0);
    for (int k = 1; k <= N; k++) cyc("R3 ring order", 1 << (k % N), k % N);

    // R4: sparse ready, pointer now 1
    for (int i = 0; i < N; i++) s_ready[i] = (i == 2 || i == 7) ? 1 : 0;
    cyc("R4 skip stalled", 1 << 2, 2);
    cyc("R4 skip stalled", 1 << 7, 7);
    cyc("R4 skip stalled wrap", 1 << 2, 2);
    clear_in();
    s_valid[3] = 0; s_ready[3] = 1;
    s_valid[5] = 1; s_ready[5] = 1;
    cyc("R4 skip invalid", 1 << 5, 5);

    // R5, R6: one slot per category
    clear_in();
    for (int i = 0; i < NC; i++) begin s_valid[i] = 1; s_ready[i] = 1; s_kind[i] = i; end
    cyc("R5 all lanes", 32'h1F, 0);
    cyc("R6 all lanes again", 32'h1F, 0);

    // R7: no-op and a spare code
    clear_in();
    s_valid[4] = 1; s_ready[4] = 1; s_kind[4] = 5;
    s_valid[6] = 1; s_ready[6] = 1; s_kind[6] = 12;
    cyc("R7 nop consumed", (1 << 4) | (1 << 6), -2);

    // R8: sleep of 3 cycles
    clear_in();
    s_valid[1] = 1; s_ready[1] = 1; s_kind[1] = 6; s_imm[1] = 3;
    cyc("R8 sleep pop", 1 << 1, -2);
    s_kind[1] = 5;
    cyc("R8 asleep", 0, -2);
    cyc("R8 asleep", 0, -2);
    cyc("R8 asleep", 0, -2);
    cyc("R8 awake", 1 << 1, -2);

    // R9: wait until count drops to 2
    clear_in();
    s_valid[2] = 1; s_ready[2] = 1; s_kind[2] = 7; s_imm[2] = 2; s_vm[2] = 4;
    cyc("R9 count high", 0, -2);
    s_vm[2] = 3;
    cyc("R9 count one over", 0, -2);
    s_vm[2] = 2;
    cyc("R9 count at limit", 1 << 2, -2);

    // R10: barrier with a straggler
    clear_in();
    s_valid[0] = 1; s_ready[0] = 1; s_kind[0] = 8;
    s_valid[1] = 1; s_ready[1] = 0; s_kind[1] = 0;
    s_valid[5] = 0; s_ready[5] = 1; s_kind[5] = 0;
    cyc("R10 waiting", 0, -2);
    s_ready[1] = 1;
    cyc("R10 straggler issues", 1 << 1, 1);
    s_kind[1] = 8;
    cyc("R10 group release", 32'h3, -2);

    // R2, R3, R6: seeded random traffic against the model
    for (int t = 0; t < 3000; t++) begin
      for (int i = 0; i < N; i++) begin
        s_valid[i] = ($urandom_range(0, 99) < 85) ? 1 : 0;
        s_ready[i] = ($urandom_range(0, 99) < 70) ? 1 : 0;
        s_kind[i]  = $urandom_range(0, 10);
        s_imm[i]   = $urandom_range(0, 5);
        s_vm[i]    = $urandom_range(0, 7);
      end
      cyc("R2 R3 R6 random", -1, -1);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule